// File: doc/BRIEF.md
# Compare-Value Timer Channel

This block is one timer channel that watches a free-running system counter supplied on an input. Software programs a compare value and a small control word. While the channel is enabled and the counter has reached or passed the compare value, the channel reports a status bit. Unless the interrupt is masked, it also drives a level interrupt.

The counter width is a parameter and may be narrower than 64 bits. In that case the compare storage has the counter's width. The upper compare bits read as zero and drop written data, and the comparison treats both operands as zero-extended unsigned values. Disabling the channel only suppresses the condition; the counter keeps running outside the block. The status bit is not sticky: it follows the current comparison, so moving the compare value above the counter clears it. The compare value has no reset and is unknown until it is first written.

Top module: `cmp_timer_channel`

## Requirements
- R1: A write to the compare value (cval_we) becomes visible on rd_data with rd_sel=0 in the following cycle. Bits below CNT_W hold the written data, and bits CNT_W and above always read as 0.
- R2: The control word reads on rd_data with rd_sel=1, with enable in bit 0, mask in bit 1 and status in bit 2. Bits 63:3 read 0. After reset, enable and mask are 0 and irq_o is 0.
- R3: Status (bit 2) is 1 in the same cycle exactly when enable is 1 and the unsigned counter is greater than or equal to the compare value.
- R4: While enable is 0, status reads 0 and irq_o is 0 whatever the counter value.
- R5: irq_o is a register: in each cycle it equals the value of (status AND NOT mask) from the previous cycle.
- R6: While mask is 1, irq_o stays 0 and status still reports the comparison.
- R7: Status is not sticky. Writing a compare value above the current counter clears status in the next cycle, and irq_o one cycle later.
- R8: A control write (ctl_we) updates only enable and mask from ctl_wdata bits 0 and 1. Bit 2 and all higher bits of the write data have no effect.
- R9: Counter equal to the compare value meets the condition, and a counter one below it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for control and interrupt state |
| cnt_i | input | CNT_W | Current system counter value |
| cval_we | input | 1 | Compare value write strobe |
| cval_wdata | input | 64 | Compare value write data |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 64 | Control write data (bit 0 enable, bit 1 mask) |
| rd_sel | input | 1 | Read select: 0 compare value, 1 control word |
| rd_data | output | 64 | Read-back data |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The condition that is hardest to reach is an exact match between a wide random counter and the compare value. Uniform random values almost never land on the boundary. The stimulus therefore places the counter at the compare value plus a small signed offset most of the time, which covers the equal case and the one-below case. It also mixes in writes that change the compare value, the mask and the enable bit while the condition holds, so status clears and the interrupt drops at the right cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned REG_W   = 64;
    localparam int unsigned BIT_EN  = 0;
    localparam int unsigned BIT_MSK = 1;
    localparam int unsigned BIT_ST  = 2;

    typedef enum logic {
        SEL_CMP = 1'b0,
        SEL_CTL = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic mask;
        logic en;
    } ctl_t;
endpackage

// File: rtl/tmr_cmp_reg.sv
module tmr_cmp_reg #(
    parameter int unsigned CNT_W = 56
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [tmr_pkg::REG_W-1:0] wdata,
    output logic [CNT_W-1:0]         cval
);
    typedef struct packed {
        logic [CNT_W-1:0] cval;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    // Upper write bits are dropped when the counter is narrow.
    generate
        if (CNT_W < tmr_pkg::REG_W) begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^wdata[tmr_pkg::REG_W-1:CNT_W];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cval = wdata[CNT_W-1:0];
        end
    end

    // No reset: the compare value is undefined until written.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cval = st_q.cval;
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [1:0]   wdata,
    output tmr_pkg::ctl_t ctl
);
    tmr_pkg::ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d.en   = wdata[tmr_pkg::BIT_EN];
            ctl_d.mask = wdata[tmr_pkg::BIT_MSK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

    // R8: a write changes only the two control bits it carries
    p_ctl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl_q.en == $past(wdata[tmr_pkg::BIT_EN]) &&
                ctl_q.mask == $past(wdata[tmr_pkg::BIT_MSK])));
endmodule

// File: rtl/tmr_cond.sv
module tmr_cond #(
    parameter int unsigned CNT_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cval,
    input  logic             en,
    input  logic             mask,
    output logic             status,
    output logic             irq
);
    localparam int unsigned EXT_W = tmr_pkg::REG_W;

    typedef struct packed {
        logic irq;
    } cond_st_t;

    cond_st_t st_d, st_q;
    logic [EXT_W-1:0] cnt_ext;
    logic [EXT_W-1:0] cval_ext;
    logic             reached;

    // Both operands are zero-extended to the full register width.
    assign cnt_ext  = EXT_W'(cnt);
    assign cval_ext = EXT_W'(cval);
    assign reached  = (cnt_ext >= cval_ext);
    assign status   = en && reached;

    always_comb begin
        st_d     = st_q;
        st_d.irq = status && !mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
    parameter int unsigned CNT_W = 56
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic                      cval_we,
    input  logic [tmr_pkg::REG_W-1:0] cval_wdata,
    input  logic                      ctl_we,
    input  logic [tmr_pkg::REG_W-1:0] ctl_wdata,
    input  logic                      rd_sel,
    output logic [tmr_pkg::REG_W-1:0] rd_data,
    output logic                      irq_o
);
    import tmr_pkg::*;

    logic [CNT_W-1:0] cval;
    ctl_t             ctl;
    logic             status;
    logic             unused_ctl_hi;

    assign unused_ctl_hi = ^ctl_wdata[REG_W-1:2];

    tmr_cmp_reg #(.CNT_W(CNT_W)) i_cmp (
        .clk   (clk),
        .we    (cval_we),
        .wdata (cval_wdata),
        .cval  (cval)
    );

    tmr_ctl i_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata[1:0]),
        .ctl   (ctl)
    );

    tmr_cond #(.CNT_W(CNT_W)) i_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (cnt_i),
        .cval   (cval),
        .en     (ctl.en),
        .mask   (ctl.mask),
        .status (status),
        .irq    (irq_o)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel_e'(rd_sel) == SEL_CMP) begin
            rd_data[CNT_W-1:0] = cval;
        end else begin
            rd_data[BIT_EN]  = ctl.en;
            rd_data[BIT_MSK] = ctl.mask;
            rd_data[BIT_ST]  = status;
        end
    end

    // R4: a disabled channel never reports the condition
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en |-> !status);

    // R5: an unmasked met condition raises the line one cycle later
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !ctl.mask) |=> irq_o);

    // R5: without an unmasked condition the line is low next cycle
    p_irq_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status || ctl.mask) |=> !irq_o);

    // R6: a set mask keeps the line low in the following cycle
    p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mask |=> !irq_o);

    generate
        if (CNT_W < REG_W) begin : g_hi_chk
            // R1: upper compare bits always read as zero
            p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_sel == 1'b0) |-> (rd_data[REG_W-1:CNT_W] == '0));
        end
    endgenerate
endmodule

// File: tb/test_cmp_timer_channel.sv
module test_cmp_timer_channel;
    localparam int unsigned CNT_W   = 56;
    localparam int unsigned CLK_PER = 10;
    localparam logic [63:0] CMASK   = (64'd1 << CNT_W) - 64'd1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_i = '0;
    logic             cval_we = 1'b0;
    logic [63:0]      cval_wdata = '0;
    logic             ctl_we = 1'b0;
    logic [63:0]      ctl_wdata = '0;
    logic             rd_sel = 1'b0;
    logic [63:0]      rd_data;
    logic             irq_o;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          finished = 1'b0;

    logic [63:0] m_cval = '0;
    logic        m_en = 1'b0;
    logic        m_mask = 1'b0;
    bit          m_known = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    cmp_timer_channel #(.CNT_W(CNT_W)) i_cmp_timer_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
        .cval_we(cval_we), .cval_wdata(cval_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic exp_status(logic [CNT_W-1:0] c);
        return m_en && ({8'd0, c} >= m_cval);
    endfunction

    function automatic logic [63:0] exp_ctl_rd(logic [CNT_W-1:0] c);
        return {61'd0, exp_status(c), m_mask, m_en};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, check combinational reads, clock, check irq.
    task automatic step(string req, logic [CNT_W-1:0] c, bit cw, logic [63:0] cd,
                        bit tw, logic [63:0] td);
        logic nxt_irq;
        cnt_i = c; cval_we = cw; cval_wdata = cd; ctl_we = tw; ctl_wdata = td;
        rd_sel = 1'b1;
        #1;
        check(req, rd_data, exp_ctl_rd(c));
        if (m_known) begin
            rd_sel = 1'b0;
            #1;
            check(req, rd_data, m_cval);
        end
        nxt_irq = exp_status(c) && !m_mask;
        if (cw) begin
            m_cval  = cd & CMASK;
            m_known = 1'b1;
        end
        if (tw) begin
            m_en   = td[0];
            m_mask = td[1];
        end
        @(posedge clk);
        @(negedge clk);
        cval_we = 1'b0; ctl_we = 1'b0;
        check(req, {63'd0, irq_o}, {63'd0, nxt_irq});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [CNT_W-1:0] base;
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rd_sel = 1'b1;
        #1;
        // R2: reset state
        check("R2", rd_data, 64'd0);
        check("R2", {63'd0, irq_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        base = CNT_W'(56'h12_3456_789A);
        // R1: write with upper bits set; they must read back zero
        step("R1", base, 1'b1, 64'hFFFF_0000_0000_0000 | 64'(base), 1'b0, 0);
        step("R1", base, 1'b0, 0, 1'b0, 0);
        // R4: condition holds but disabled
        step("R4", base + 5, 1'b0, 0, 1'b0, 0);
        // R8: set enable, junk in bit 2 and high bits
        step("R8", base + 5, 1'b0, 0, 1'b1, 64'hF0F0_0000_0000_0005);
        step("R8", base + 5, 1'b0, 0, 1'b0, 0);
        // R9: one below, then equal
        step("R9", base - 1, 1'b0, 0, 1'b0, 0);
        step("R9", base, 1'b0, 0, 1'b0, 0);
        step("R3", base + 1, 1'b0, 0, 1'b0, 0);
        // R7: raise compare above counter, status and irq clear
        step("R7", base + 1, 1'b1, 64'(base) + 64'd100, 1'b0, 0);
        step("R7", base + 1, 1'b0, 0, 1'b0, 0);
        step("R7", base + 1, 1'b0, 0, 1'b0, 0);
        // R6: mask set while condition holds
        step("R6", base + 200, 1'b0, 0, 1'b1, 64'd3);
        step("R6", base + 200, 1'b0, 0, 1'b0, 0);
        step("R6", base + 300, 1'b0, 0, 1'b1, 64'd1);
        step("R5", base + 300, 1'b0, 0, 1'b0, 0);
        // R1: all-ones within width, top of counter range
        step("R1", '1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0);
        step("R9", '1, 1'b0, 0, 1'b0, 0);
        step("R9", '1 - 1, 1'b0, 0, 1'b0, 0);
        // R3/R5: random mix, counter near the compare value mostly
        for (int i = 0; i < 400; i++) begin
            logic [CNT_W-1:0] c;
            logic [63:0]      r;
            bit               cw, tw;
            r  = {$urandom, $urandom};
            cw = ($urandom % 8) == 0;
            tw = ($urandom % 10) == 0;
            if (($urandom % 4) != 0)
                c = m_cval[CNT_W-1:0] + CNT_W'(int'($urandom % 5) - 2);
            else
                c = r[CNT_W-1:0];
            step("R3", c, cw, {$urandom, $urandom}, tw, 64'($urandom));
        end
        finish_run();
    end
endmodule